// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler and destuffer. Each destuffed bit arrives with a one-cycle strobe and its position in the frame, with position 0 being the start-of-frame bit. The parser sorts every bit into its field and holds the decoded frame on its outputs. It decodes base and extended frames, both data and remote. The fields are the identifier, extended identifier, combined identifier, the RTR/SRR/IDE and reserved bits, the length code, the data bytes, the CRC sequence and the acknowledge slot.

The field layout splits on the IDE bit. The position of the last data bit is derived from the length code and is exported to the destuffer, which stops stuff-bit removal near the frame tail. Protocol-rule breaks are collected as sticky per-frame flags rather than aborting the decode. A one-cycle done pulse marks the last end-of-frame bit, and at that point every field and every flag is final. CRC verification, error and overload frames, and transmission belong to other blocks.

Top module: `can_field_parser`

## Requirements
- R1: After reset all field outputs, flags and the done pulse are 0, and the last-data-bit index reads all ones.
- R2: A strobe at position 0 starts a new frame. It clears all fields and flags, and it sets error bit 0 if that bit is 1 (start of frame must be dominant).
- R3: Positions 1..11 form the 11-bit base identifier, MSB first. Error bit 1 is set when identifier bits 10..4 are all 1.
- R4: Position 13 is IDE (0 = base, 1 = extended). In a base frame, position 12 is RTR (1 = remote), position 14 is reserved bit 0, and positions 15..18 are the 4-bit length code, MSB first. SRR reads 0.
- R5: In an extended frame, position 12 is SRR and positions 14..31 are the 18-bit extended identifier, MSB first. Position 32 is RTR, 33 is reserved bit 1, 34 is reserved bit 0, and 35..38 are the length code. The full identifier output is {base id, extended id} for extended frames and the zero-extended base id for base frames.
- R6: From the cycle after the final length-code bit (position 18 base / 38 extended), the last-data-bit index equals that position plus 8 times the length code for data frames. For remote frames it equals that position alone.
- R7: Data bits follow the length code MSB first, and byte k is presented at data_o[k]. Only the first 8 bytes are stored. The byte count equals the smaller of the length code and 8, and it is 0 for remote frames. Bytes that were not received read 0. A length code above 8 sets error bit 2.
- R8: The 15 bits after the last data bit form the CRC sequence, MSB first. The next bit is the CRC delimiter, and a 0 there sets error bit 3. The bit after that is the ACK slot, and ack_o is 1 when it was 0. The ACK delimiter follows, and a 0 there sets error bit 4.
- R9: The seven end-of-frame bits follow. Any 0 among them sets error bit 5. frame_done_o pulses for one cycle, in the cycle after the strobe at position last+25, with all fields and flags final.
- R10: Cycles with bit_vld_i low change nothing, whatever bit_i and bit_idx_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_vld_i | input | 1 | Destuffed bit strobe |
| bit_i | input | 1 | Bit value (0 dominant) |
| bit_idx_i | input | IDX_W | Position of the bit in the frame |
| base_id_o | output | 11 | Base identifier |
| ext_id_o | output | 18 | Extended identifier |
| full_id_o | output | 29 | Combined identifier |
| ide_o | output | 1 | 1 for extended frame |
| rtr_o | output | 1 | 1 for remote frame |
| srr_o | output | 1 | SRR bit (extended only) |
| rsv0_o | output | 1 | Reserved bit 0 |
| rsv1_o | output | 1 | Reserved bit 1 (extended only) |
| dlc_o | output | 4 | Length code |
| data_o | output | NB x 8 | Data bytes, byte k at index k |
| byte_cnt_o | output | 4 | Stored byte count |
| crc_o | output | 15 | CRC sequence |
| ack_o | output | 1 | 1 when ACK slot was dominant |
| last_data_idx_o | output | IDX_W | Position of the last data bit |
| err_o | output | 6 | Sticky per-frame error flags |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong IDE or length-code register moves every later field. The fault shows first on last_data_idx_o one cycle after the final length-code bit, and later as a done pulse at the wrong position or a missing done pulse. A mis-indexed shift register shows as wrong identifier, CRC or data byte values at the done pulse. A flag that is not cleared by the next start-of-frame shows in the following clean frame's error vector.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;
  localparam int ERR_W      = 6;
  localparam int ERR_SOF    = 0;
  localparam int ERR_ID     = 1;
  localparam int ERR_DLC    = 2;
  localparam int ERR_CRCDLM = 3;
  localparam int ERR_ACKDLM = 4;
  localparam int ERR_EOF    = 5;

  localparam int ID_W   = 11;
  localparam int EID_W  = 18;
  localparam int DLC_W  = 4;
  localparam int CRC_W  = 15;

  localparam int BASE_DLC_END = 18;
  localparam int EXT_DLC_END  = 38;
  localparam int TAIL_LEN     = 25;

  typedef logic [ERR_W-1:0] err_t;
endpackage

// File: rtl/can_hdr_decode.sv
module can_hdr_decode
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     bit_idx_i,
  output logic [ID_W-1:0]      base_id_o,
  output logic [EID_W-1:0]     ext_id_o,
  output logic                 ide_o,
  output logic                 rtr_o,
  output logic                 srr_o,
  output logic                 rsv0_o,
  output logic                 rsv1_o,
  output logic [DLC_W-1:0]     dlc_o,
  output logic [IDX_W-1:0]     last_idx_o,
  output logic                 sof_ev_o,
  output logic                 id_ev_o,
  output logic                 dlc_ev_o
);
  localparam logic [IDX_W-1:0] P_ID_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] P_ID_LAST  = IDX_W'(ID_W);
  localparam logic [IDX_W-1:0] P_B12      = IDX_W'(12);
  localparam logic [IDX_W-1:0] P_IDE      = IDX_W'(13);
  localparam logic [IDX_W-1:0] P_B_RSV0   = IDX_W'(14);
  localparam logic [IDX_W-1:0] P_B_DLC0   = IDX_W'(BASE_DLC_END - DLC_W + 1);
  localparam logic [IDX_W-1:0] P_B_DLC3   = IDX_W'(BASE_DLC_END);
  localparam logic [IDX_W-1:0] P_E_EID0   = IDX_W'(14);
  localparam logic [IDX_W-1:0] P_E_EID17  = IDX_W'(14 + EID_W - 1);
  localparam logic [IDX_W-1:0] P_E_RTR    = IDX_W'(32);
  localparam logic [IDX_W-1:0] P_E_RSV1   = IDX_W'(33);
  localparam logic [IDX_W-1:0] P_E_RSV0   = IDX_W'(34);
  localparam logic [IDX_W-1:0] P_E_DLC0   = IDX_W'(EXT_DLC_END - DLC_W + 1);
  localparam logic [IDX_W-1:0] P_E_DLC3   = IDX_W'(EXT_DLC_END);
  localparam logic [DLC_W-1:0] DLC_MAX    = DLC_W'(8);

  logic [ID_W-1:0]  id_q;
  logic [EID_W-1:0] eid_q;
  logic             ide_q, b12_q, rtr_x_q, rsv0_q, rsv1_q;
  logic [DLC_W-1:0] dlc_q;
  logic [IDX_W-1:0] last_q;

  logic             sof;
  logic             remote;
  logic [IDX_W-1:0] dlc_end;
  logic [ID_W-1:0]  id_nxt;
  logic [DLC_W-1:0] dlc_nxt;
  logic [IDX_W-1:0] last_nxt;
  logic             in_id, in_eid, in_dlc;

  always_comb begin
    sof      = bit_vld_i && (bit_idx_i == '0);
    remote   = ide_q ? rtr_x_q : b12_q;
    dlc_end  = ide_q ? P_E_DLC3 : P_B_DLC3;
    id_nxt   = {id_q[ID_W-2:0], bit_i};
    dlc_nxt  = {dlc_q[DLC_W-2:0], bit_i};
    last_nxt = remote ? dlc_end : dlc_end + IDX_W'({dlc_nxt, 3'b000});
    in_id    = (bit_idx_i >= P_ID_FIRST) && (bit_idx_i <= P_ID_LAST);
    in_eid   = ide_q && (bit_idx_i >= P_E_EID0) && (bit_idx_i <= P_E_EID17);
    in_dlc   = ide_q ? ((bit_idx_i >= P_E_DLC0) && (bit_idx_i <= P_E_DLC3))
                     : ((bit_idx_i >= P_B_DLC0) && (bit_idx_i <= P_B_DLC3));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= '0; eid_q <= '0; ide_q <= 1'b0; b12_q <= 1'b0;
      rtr_x_q <= 1'b0; rsv0_q <= 1'b0; rsv1_q <= 1'b0;
      dlc_q <= '0; last_q <= '1;
    end else if (sof) begin
      id_q <= '0; eid_q <= '0; ide_q <= 1'b0; b12_q <= 1'b0;
      rtr_x_q <= 1'b0; rsv0_q <= 1'b0; rsv1_q <= 1'b0;
      dlc_q <= '0; last_q <= '1;
    end else if (bit_vld_i) begin
      if (in_id)                  id_q  <= id_nxt;
      if (bit_idx_i == P_B12)     b12_q <= bit_i;
      if (bit_idx_i == P_IDE)     ide_q <= bit_i;
      if (in_eid)                 eid_q <= {eid_q[EID_W-2:0], bit_i};
      if (in_dlc)                 dlc_q <= dlc_nxt;
      if (!ide_q && bit_idx_i == P_B_RSV0) rsv0_q  <= bit_i;
      if (ide_q && bit_idx_i == P_E_RTR)   rtr_x_q <= bit_i;
      if (ide_q && bit_idx_i == P_E_RSV1)  rsv1_q  <= bit_i;
      if (ide_q && bit_idx_i == P_E_RSV0)  rsv0_q  <= bit_i;
      if (bit_idx_i == dlc_end)   last_q <= last_nxt;
    end
  end

  assign sof_ev_o = sof && bit_i;
  assign id_ev_o  = bit_vld_i && (bit_idx_i == P_ID_LAST) && (&id_nxt[ID_W-1:4]);
  assign dlc_ev_o = bit_vld_i && (bit_idx_i == dlc_end) && (dlc_nxt > DLC_MAX);

  assign base_id_o  = id_q;
  assign ext_id_o   = eid_q;
  assign ide_o      = ide_q;
  assign rtr_o      = remote;
  assign srr_o      = ide_q & b12_q;
  assign rsv0_o     = rsv0_q;
  assign rsv1_o     = rsv1_q;
  assign dlc_o      = dlc_q;
  assign last_idx_o = last_q;

  AST_LAST_NOT_BEFORE_DLC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && bit_idx_i < P_B_DLC3) |=> (last_idx_o == '1)) else $error("last idx early"); // R6
endmodule

// File: rtl/can_data_collect.sv
module can_data_collect
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NB    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     bit_idx_i,
  input  logic                 ide_i,
  input  logic                 rtr_i,
  input  logic [DLC_W-1:0]     dlc_i,
  input  logic [IDX_W-1:0]     last_idx_i,
  output logic [NB-1:0][7:0]   data_o,
  output logic [DLC_W-1:0]     byte_cnt_o
);
  localparam int SEL_W = IDX_W - 3;
  localparam logic [IDX_W-1:0] P_B_DATA0 = IDX_W'(BASE_DLC_END + 1);
  localparam logic [IDX_W-1:0] P_E_DATA0 = IDX_W'(EXT_DLC_END + 1);
  localparam logic [DLC_W-1:0] NB_CAP    = DLC_W'(NB);

  logic             sof, hit;
  logic [IDX_W-1:0] start, off;
  logic [SEL_W-1:0] sel;
  logic [2:0]       bpos;

  always_comb begin
    sof   = bit_vld_i && (bit_idx_i == '0);
    start = ide_i ? P_E_DATA0 : P_B_DATA0;
    hit   = bit_vld_i && !rtr_i && (bit_idx_i >= start) && (bit_idx_i <= last_idx_i);
    off   = bit_idx_i - start;
    sel   = off[IDX_W-1:3];
    bpos  = 3'd7 - off[2:0];
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         byte_q <= '0;
      else if (sof)                        byte_q <= '0;
      else if (hit && sel == SEL_W'(g))    byte_q[bpos] <= bit_i;
    end
    assign data_o[g] = byte_q;
  end

  assign byte_cnt_o = rtr_i ? '0 : ((dlc_i > NB_CAP) ? NB_CAP : dlc_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_o <= NB_CAP) else $error("byte count above cap"); // R7
endmodule

// File: rtl/can_tail_check.sv
module can_tail_check
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     bit_idx_i,
  input  logic [IDX_W-1:0]     last_idx_i,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 ack_o,
  output logic                 done_o,
  output logic                 crc_dlm_ev_o,
  output logic                 ack_dlm_ev_o,
  output logic                 eof_ev_o
);
  localparam logic [IDX_W:0] R_CRC_LAST = (IDX_W+1)'(CRC_W);
  localparam logic [IDX_W:0] R_CRC_DLM  = (IDX_W+1)'(CRC_W + 1);
  localparam logic [IDX_W:0] R_ACK      = (IDX_W+1)'(CRC_W + 2);
  localparam logic [IDX_W:0] R_ACK_DLM  = (IDX_W+1)'(CRC_W + 3);
  localparam logic [IDX_W:0] R_EOF0     = (IDX_W+1)'(CRC_W + 4);
  localparam logic [IDX_W:0] R_END      = (IDX_W+1)'(TAIL_LEN);

  logic             sof, in_tail;
  logic [IDX_W:0]   rel;
  logic [CRC_W-1:0] crc_q;
  logic             ack_q, done_q;

  always_comb begin
    sof     = bit_vld_i && (bit_idx_i == '0);
    in_tail = bit_vld_i && ({1'b0, bit_idx_i} > {1'b0, last_idx_i});
    rel     = {1'b0, bit_idx_i} - {1'b0, last_idx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0; ack_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= in_tail && (rel == R_END);
      if (sof) begin
        crc_q <= '0;
        ack_q <= 1'b0;
      end else if (in_tail) begin
        if (rel <= R_CRC_LAST) crc_q <= {crc_q[CRC_W-2:0], bit_i};
        if (rel == R_ACK)      ack_q <= !bit_i;
      end
    end
  end

  assign crc_dlm_ev_o = in_tail && (rel == R_CRC_DLM) && !bit_i;
  assign ack_dlm_ev_o = in_tail && (rel == R_ACK_DLM) && !bit_i;
  assign eof_ev_o     = in_tail && (rel >= R_EOF0) && (rel <= R_END) && !bit_i;
  assign crc_o  = crc_q;
  assign ack_o  = ack_q;
  assign done_o = done_q;

  AST_IDLE_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(crc_o)) else $error("crc moved without strobe"); // R10
  AST_IDLE_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(ack_o)) else $error("ack moved without strobe"); // R10
endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NB    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     bit_idx_i,
  output logic [ID_W-1:0]      base_id_o,
  output logic [EID_W-1:0]     ext_id_o,
  output logic [ID_W+EID_W-1:0] full_id_o,
  output logic                 ide_o,
  output logic                 rtr_o,
  output logic                 srr_o,
  output logic                 rsv0_o,
  output logic                 rsv1_o,
  output logic [DLC_W-1:0]     dlc_o,
  output logic [NB-1:0][7:0]   data_o,
  output logic [DLC_W-1:0]     byte_cnt_o,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 ack_o,
  output logic [IDX_W-1:0]     last_data_idx_o,
  output logic [ERR_W-1:0]     err_o,
  output logic                 frame_done_o
);
  logic sof_ev, id_ev, dlc_ev, crc_dlm_ev, ack_dlm_ev, eof_ev;
  err_t ev, err_q;
  logic sof;

  can_hdr_decode #(.IDX_W(IDX_W)) u_hdr (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .bit_idx_i,
    .base_id_o, .ext_id_o, .ide_o, .rtr_o, .srr_o, .rsv0_o, .rsv1_o, .dlc_o,
    .last_idx_o(last_data_idx_o),
    .sof_ev_o(sof_ev), .id_ev_o(id_ev), .dlc_ev_o(dlc_ev)
  );

  can_data_collect #(.IDX_W(IDX_W), .NB(NB)) u_data (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .bit_idx_i,
    .ide_i(ide_o), .rtr_i(rtr_o), .dlc_i(dlc_o), .last_idx_i(last_data_idx_o),
    .data_o, .byte_cnt_o
  );

  can_tail_check #(.IDX_W(IDX_W)) u_tail (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .bit_idx_i,
    .last_idx_i(last_data_idx_o),
    .crc_o, .ack_o, .done_o(frame_done_o),
    .crc_dlm_ev_o(crc_dlm_ev), .ack_dlm_ev_o(ack_dlm_ev), .eof_ev_o(eof_ev)
  );

  always_comb begin
    ev = '0;
    ev[ERR_SOF]    = sof_ev;
    ev[ERR_ID]     = id_ev;
    ev[ERR_DLC]    = dlc_ev;
    ev[ERR_CRCDLM] = crc_dlm_ev;
    ev[ERR_ACKDLM] = ack_dlm_ev;
    ev[ERR_EOF]    = eof_ev;
    sof = bit_vld_i && (bit_idx_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= '0;
    else if (sof)       err_q <= ev;
    else if (bit_vld_i) err_q <= err_q | ev;
  end

  assign err_o     = err_q;
  assign full_id_o = ide_o ? {base_id_o, ext_id_o} : {{EID_W{1'b0}}, base_id_o};

  AST_DONE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(bit_vld_i)) else $error("done without strobe"); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o) else $error("done longer than one cycle"); // R9
  AST_DLC_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (err_o[ERR_DLC] == (dlc_o > DLC_W'(8)))) else $error("dlc flag mismatch"); // R7
  AST_ERR_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && bit_idx_i == '0) |=> (err_o[ERR_W-1:1] == '0)) else $error("flags not cleared"); // R2
  AST_REMOTE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && rtr_o) |-> (byte_cnt_o == '0)) else $error("remote frame with bytes"); // R7
endmodule

// File: tb/can_field_parser_tb.sv
module can_field_parser_tb;
  localparam int IDX_W = 8;
  localparam int NB    = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_vld_i = 1'b0;
  logic bit_i = 1'b1;
  logic [IDX_W-1:0] bit_idx_i = '0;
  logic [10:0] base_id_o;
  logic [17:0] ext_id_o;
  logic [28:0] full_id_o;
  logic ide_o, rtr_o, srr_o, rsv0_o, rsv1_o, ack_o, frame_done_o;
  logic [3:0] dlc_o, byte_cnt_o;
  logic [NB-1:0][7:0] data_o;
  logic [14:0] crc_o;
  logic [IDX_W-1:0] last_data_idx_o;
  logic [5:0] err_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  can_field_parser #(.IDX_W(IDX_W), .NB(NB)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  logic fr [0:255];
  int   fr_n;

  task automatic put(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      fr[fr_n] = v[k];
      fr_n++;
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed + 8'(k * 59);
  endfunction

  task automatic run_frame(input string name, input bit ide, input logic [10:0] id,
                           input logic [17:0] eid, input bit rtr, input logic [3:0] dlc,
                           input logic [7:0] seed, input logic [14:0] crc, input bit ack,
                           input bit sof_bad, input bit crcd_bad, input bit ackd_bad,
                           input bit eof_bad);
    int dlc_end, exp_last, early, nbytes;
    logic [5:0] exp_err;
    fr_n = 0;
    put(sof_bad, 1);
    put(id, 11);
    if (!ide) begin
      put(rtr, 1); put(0, 1); put(0, 1); put(dlc, 4);
    end else begin
      put(1, 1); put(1, 1); put(eid, 18); put(rtr, 1); put(0, 1); put(0, 1); put(dlc, 4);
    end
    if (!rtr) for (int k = 0; k < dlc; k++) put(pat(seed, k), 8);
    put(crc, 15);
    put(!crcd_bad, 1);
    put(!ack, 1);
    put(!ackd_bad, 1);
    put(eof_bad ? 7'b1110111 : 7'b1111111, 7);
    dlc_end  = ide ? 38 : 18;
    exp_last = dlc_end + (rtr ? 0 : 8 * dlc);
    exp_err  = {eof_bad, ackd_bad, crcd_bad, (dlc > 8), (id[10:4] == 7'h7f), sof_bad};
    nbytes   = rtr ? 0 : (dlc > 8 ? 8 : dlc);
    early = 0;
    for (int i = 0; i < fr_n; i++) begin
      @(negedge clk_i);
      bit_vld_i = 1'b1; bit_i = fr[i]; bit_idx_i = IDX_W'(i);
      @(negedge clk_i);
      bit_vld_i = 1'b0; bit_i = 1'b0; bit_idx_i = '0;  // R10: junk while strobe is low
      if (i == 5) chk({name, " R6 idx before dlc"}, last_data_idx_o, 8'hff);
      if (i == dlc_end) chk({name, " R6 last data idx"}, last_data_idx_o, exp_last);
      if (i < fr_n - 1 && frame_done_o) early++;
    end
    chk({name, " R9 frame_done pulse"}, frame_done_o, 1);
    chk({name, " R9 no early done"}, early, 0);
    chk({name, " R3 base id"}, base_id_o, id);
    chk({name, " R4 ide"}, ide_o, ide);
    chk({name, " R4 rtr"}, rtr_o, rtr);
    chk({name, " R5 srr"}, srr_o, ide);
    chk({name, " R5 reserved"}, {rsv1_o, rsv0_o}, 0);
    chk({name, " R5 ext id"}, ext_id_o, ide ? eid : 18'd0);
    chk({name, " R5 full id"}, full_id_o, ide ? {id, eid} : {18'd0, id});
    chk({name, " R4 dlc"}, dlc_o, dlc);
    chk({name, " R7 byte count"}, byte_cnt_o, nbytes);
    for (int k = 0; k < NB; k++)
      chk($sformatf("%s R7 byte %0d", name, k), data_o[k], (k < nbytes) ? pat(seed, k) : 8'h00);
    chk({name, " R8 crc"}, crc_o, crc);
    chk({name, " R8 ack"}, ack_o, ack);
    chk({name, " R2 R9 error flags"}, err_o, exp_err);
    @(negedge clk_i);
    chk({name, " R9 done drops"}, frame_done_o, 0);
    chk({name, " R10 flags held"}, err_o, exp_err);
  endtask

  task automatic t_reset;
    chk("R1 frame_done", frame_done_o, 0);
    chk("R1 ids", {base_id_o, ext_id_o}, 0);
    chk("R1 flags", err_o, 0);
    chk("R1 last idx", last_data_idx_o, 8'hff);
    chk("R1 count crc ack", {byte_cnt_o, crc_o, ack_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_frame("base data", 0, 11'h123, 0, 0, 4'd2, 8'hA5, 15'h1abc, 1, 0, 0, 0, 0);
    run_frame("ext data8", 1, 11'h0F1, 18'h2A5C3, 0, 4'd8, 8'h11, 15'h7001, 1, 0, 0, 0, 0);
    run_frame("base remote", 0, 11'h055, 0, 1, 4'd4, 8'h00, 15'h0f0f, 0, 0, 0, 0, 0);
    run_frame("ext remote", 1, 11'h400, 18'h00001, 1, 4'd3, 8'h00, 15'h4321, 1, 0, 0, 0, 0);
    run_frame("ext dlc12", 1, 11'h2AA, 18'h15555, 0, 4'd12, 8'h3C, 15'h2222, 1, 0, 0, 0, 0);
    run_frame("base bad", 0, 11'h7F5, 0, 0, 4'd1, 8'h80, 15'h7fff, 0, 1, 1, 1, 1);
    run_frame("base dlc0 clean", 0, 11'h000, 0, 0, 4'd0, 8'h00, 15'h0001, 1, 0, 0, 0, 0);
    run_frame("ext dlc8 max", 1, 11'h7EF, 18'h3FFFF, 0, 4'd8, 8'hFE, 15'h5a5a, 1, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule